// File: doc/BRIEF.md
# Two-level carry-lookahead adder, 16 bits

This block adds two 16-bit operands and an incoming carry in one combinational path and gives the 16-bit sum and the outgoing carry. It does not ripple the carry from bit to bit. The operands are split into four 4-bit slices. Inside each slice, every carry is a flat sum-of-products of per-bit generate and propagate terms and the slice's incoming carry. A second lookahead stage forms the carry into each slice and the final carry from the slices' own propagate and generate pairs. Those pairs use the same equations as the bit-level terms.

The combined propagate and generate of the whole 16-bit word are also outputs. A wider adder can therefore place this block under a third lookahead level. Propagate is the OR of the operand bits, not the XOR. For this reason each sum bit comes from both operand bits and the carry into that bit.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals bits 15..0 of the 17-bit total `a_i + b_i + c_i`, for every input combination.
- R2: `c_o` equals bit 16 of the 17-bit total `a_i + b_i + c_i`.
- R3: `p_o` is 1 exactly when every bit position k has `a_i[k] | b_i[k]` equal to 1.
- R4: `g_o` is 1 exactly when `a_i + b_i`, with no incoming carry, does not fit in 16 bits.
- R5: `c_o` equals `g_o | (p_o & c_i)` for every input combination.
- R6: A carry leaving slice k (bits 4k+3..4k) reaches slice k+1 and is added into it, for slices 0 to 2. This holds whether the carry is generated inside slice k or passes through it from below.
- R7: With both operands all ones, or with one operand all ones, the other zero and `c_i` = 1, the carry crosses all four slices: the sum is `16'hFFFF` and `16'h0000` respectively, and `c_o` is 1 in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_i | input | 1 | Incoming carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c_o | output | 1 | Outgoing carry from bit 15 |
| p_o | output | 1 | Word-level propagate for cascading |
| g_o | output | 1 | Word-level generate for cascading |

## Verification
Each slice is tried with every pair of 4-bit operand values in that slice, the other bits zero, and both carry-in values. This shows whether the bit-level equations are correct in isolation. The same exhaustive sweep is repeated with the bits below the slice set up to deliver a carry into it, which exposes a wrong or missing second-level carry into one particular slice. Fixed corner vectors follow: all ones plus one, alternating bit patterns, and sign-bit collisions. Random operands then mix generate and propagate chains across slice edges. The propagate and generate outputs are compared on every vector, so an AND/XOR substitution in the propagate term shows up.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GRP_W  = 4;
  localparam int unsigned NUM_GRP = 4;
  localparam int unsigned DATA_W = GRP_W * NUM_GRP;

  typedef logic [GRP_W-1:0]   grp_vec_t;
  typedef logic [NUM_GRP-1:0] grp_flag_t;
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg
  import cla_pkg::*;
(
  input  grp_vec_t a_i,
  input  grp_vec_t b_i,
  output grp_vec_t g_o,
  output grp_vec_t p_o
);
  for (genvar k = 0; k < GRP_W; k++) begin : g_bit
    assign g_o[k] = a_i[k] & b_i[k];
    assign p_o[k] = a_i[k] | b_i[k];
  end
endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4 (
  input  logic [3:0] g_i,
  input  logic [3:0] p_i,
  input  logic       c_i,
  output logic [3:1] c_int_o,
  output logic       c_o,
  output logic       p_o,
  output logic       g_o
);
  assign c_int_o[1] = g_i[0] | (p_i[0] & c_i);
  assign c_int_o[2] = g_i[1] | (p_i[1] & g_i[0]) | (p_i[1] & p_i[0] & c_i);
  assign c_int_o[3] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0])
                    | (p_i[2] & p_i[1] & p_i[0] & c_i);
  assign c_o = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
             | (p_i[3] & p_i[2] & p_i[1] & g_i[0])
             | (p_i[3] & p_i[2] & p_i[1] & p_i[0] & c_i);
  assign p_o = p_i[0] & p_i[1] & p_i[2] & p_i[3];
  assign g_o = g_i[3] | (g_i[2] & p_i[3]) | (g_i[1] & p_i[2] & p_i[3])
             | (g_i[0] & p_i[1] & p_i[2] & p_i[3]);

  // flat carry-out must match the cascade form built from group terms
  always_comb begin
    assert_cout_form_R5: assert (c_o == (g_o | (p_o & c_i)))
      else $error("lookahead carry-out disagrees with P/G form");
  end
endmodule

// File: rtl/cla_group4.sv
module cla_group4
  import cla_pkg::*;
(
  input  grp_vec_t a_i,
  input  grp_vec_t b_i,
  input  logic     c_i,
  output grp_vec_t sum_o,
  output logic     p_o,
  output logic     g_o
);
  grp_vec_t g, p;
  logic [3:1] c_int;
  logic       c_unused;
  logic [GRP_W:0] chk_tot;

  cla_bit_pg i_pg (
    .a_i (a_i),
    .b_i (b_i),
    .g_o (g),
    .p_o (p)
  );

  cla_lookahead4 i_la (
    .g_i     (g),
    .p_i     (p),
    .c_i     (c_i),
    .c_int_o (c_int),
    .c_o     (c_unused),
    .p_o     (p_o),
    .g_o     (g_o)
  );

  // p is OR-based, so sum needs the operand XOR explicitly
  assign sum_o = a_i ^ b_i ^ {c_int, c_i};

  always_comb begin
    chk_tot = {1'b0, a_i} + {1'b0, b_i} + {{GRP_W{1'b0}}, c_i};
    assert_grp_sum_R1: assert (sum_o == chk_tot[GRP_W-1:0])
      else $error("group sum wrong");
    assert_grp_cout_R6: assert ((g_o | (p_o & c_i)) == chk_tot[GRP_W])
      else $error("group carry term wrong");
    assert_grp_int_R6: assert (c_unused == chk_tot[GRP_W])
      else $error("group flat carry wrong");
  end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
(
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic        c_i,
  output logic [15:0] sum_o,
  output logic        c_o,
  output logic        p_o,
  output logic        g_o
);
  grp_flag_t  grp_p, grp_g;
  logic [NUM_GRP-1:0] grp_cin;
  logic [3:1] c_int;
  logic [DATA_W:0] chk_tot;
  logic [DATA_W:0] chk_nc;

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
    cla_group4 i_grp (
      .a_i   (a_i[k*GRP_W +: GRP_W]),
      .b_i   (b_i[k*GRP_W +: GRP_W]),
      .c_i   (grp_cin[k]),
      .sum_o (sum_o[k*GRP_W +: GRP_W]),
      .p_o   (grp_p[k]),
      .g_o   (grp_g[k])
    );
  end

  cla_lookahead4 i_top_la (
    .g_i     (grp_g),
    .p_i     (grp_p),
    .c_i     (c_i),
    .c_int_o (c_int),
    .c_o     (c_o),
    .p_o     (p_o),
    .g_o     (g_o)
  );

  assign grp_cin = {c_int, c_i};

  always_comb begin
    chk_tot = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, c_i};
    chk_nc  = {1'b0, a_i} + {1'b0, b_i};
    assert_sum_R1: assert (sum_o == chk_tot[DATA_W-1:0]) else $error("sum wrong");
    assert_cout_R2: assert (c_o == chk_tot[DATA_W]) else $error("carry-out wrong");
    assert_gen_R4: assert (g_o == chk_nc[DATA_W]) else $error("generate wrong");
    assert_prop_R3: assert (!p_o || (chk_nc[DATA_W-1:0] == '1) || chk_nc[DATA_W])
      else $error("propagate set without full chain");
  end
endmodule

// File: tb/test_cla_adder16.sv
module test_cla_adder16;
  localparam int unsigned CLK_HALF = 2;
  localparam int unsigned TIMEOUT  = 400000;
  localparam int unsigned N_VEC    = 12;
  localparam int unsigned N_RAND   = 3000;

  // {a, b, ci, exp_sum, exp_co}
  localparam logic [49:0] VEC [N_VEC] = '{
    {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
    {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1},
    {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1},
    {16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0},
    {16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0},
    {16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0},
    {16'h0FFF, 16'h0001, 1'b0, 16'h1000, 1'b0},
    {16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0},
    {16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1},
    {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1},
    {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0}
  };

  logic clk = 1'b0;
  logic [15:0] a, b, sum;
  logic ci, co, p, g;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_HALF) clk = ~clk;

  cla_adder16 i_cla_adder16 (
    .a_i   (a),
    .b_i   (b),
    .c_i   (ci),
    .sum_o (sum),
    .c_o   (co),
    .p_o   (p),
    .g_o   (g)
  );

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h ci=%0d actual=%h expected=%h", tag, a, b, ci, act, exp);
    end
  endtask

  // drive at negedge, sample mid low phase
  task automatic run(input string tag, input logic [15:0] av, input logic [15:0] bv,
                     input logic civ);
    logic [16:0] tot, nc;
    @(negedge clk);
    a = av; b = bv; ci = civ;
    #1;
    tot = {1'b0, av} + {1'b0, bv} + {16'b0, civ};
    nc  = {1'b0, av} + {1'b0, bv};
    cmp({tag, " R1 sum"}, sum, tot[15:0]);
    cmp({tag, " R2 cout"}, {15'b0, co}, {15'b0, tot[16]});
    cmp({tag, " R3 prop"}, {15'b0, p}, {15'b0, &(av | bv)});
    cmp({tag, " R4 gen"}, {15'b0, g}, {15'b0, nc[16]});
    cmp({tag, " R5 cascade"}, {15'b0, co}, {15'b0, g | (p & civ)});
  endtask

  initial begin
    #(TIMEOUT);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    // idle inputs give all-zero outputs (R1, R2)
    @(negedge clk); #1;
    cmp("idle R1 sum", sum, 16'h0000);
    cmp("idle R2 cout", {15'b0, co}, 16'h0000);

    for (int i = 0; i < N_VEC; i++) begin
      run("table", VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
      cmp("table R1 literal", sum, VEC[i][16:1]);
      cmp("table R2 literal", {15'b0, co}, {15'b0, VEC[i][0]});
    end

    // exhaustive per slice, isolated and with a carry delivered from below (R6)
    for (int k = 0; k < 4; k++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          for (int c = 0; c < 2; c++) begin
            logic [15:0] av, bv, low;
            av  = 16'(x) << (4 * k);
            bv  = 16'(y) << (4 * k);
            low = (16'h1 << (4 * k)) - 16'h1;
            run("slice", av, bv, c[0]);
            if (k > 0) run("slice R6 carry-in", av | low, bv, 1'b1);
          end
        end
      end
    end

    // R7 full-width ripple cases
    run("R7 ones+ones+1", 16'hFFFF, 16'hFFFF, 1'b1);
    cmp("R7 sum", sum, 16'hFFFF);
    cmp("R7 cout", {15'b0, co}, 16'h0001);
    run("R7 ones+0+1", 16'hFFFF, 16'h0000, 1'b1);
    cmp("R7 sum", sum, 16'h0000);
    cmp("R7 cout", {15'b0, co}, 16'h0001);
    cmp("R7 prop", {15'b0, p}, 16'h0001);

    for (int i = 0; i < N_RAND; i++)
      run("random", 16'($urandom), 16'($urandom), 1'($urandom));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule